// File: doc/BRIEF.md
# DRAM Refresh and Test-Mode Control

This block is the device-side cycle decoder of an asynchronous DRAM, modelled with a sampling clock. It watches the active-low row strobe, column strobe, write enable and output enable. It sorts every row-strobe cycle into one of four kinds: an ordinary access, a row-only refresh, a column-before-row (CBR) refresh, or a test-mode entry. It keeps the internal refresh row counter. It chooses whether the refreshed row comes from the address pins or from that counter. A small behavioural cell array stands in for the storage. A debug strobe reports every refreshed row, so a bench can confirm that every row gets covered.

The cycle kind is fixed at the sampled falling edge of the row strobe.
- With the column strobe high, the FSM goes from `ST_IDLE` to `ST_ROW_OPEN` and latches the row from the address.
- With the column strobe low and write enable high, it goes to `ST_CBR_REF`.
- With both low, it goes to `ST_TEST_ENTRY`.
- From any of these three states, a rising row strobe returns the FSM to `ST_IDLE`.

If a row-open cycle closes without any column strobe, it counts as a row-only refresh. In test mode the two lowest column bits are ignored. Each written bit then lands in four cells, and a read returns a per-bit agreement flag.

Top module: `dram_refresh_ctl`

## Requirements
- R1: After reset, `dq_oe` and `refresh_stb` are 0, and the first CBR-type refresh reports row 0.
- R2: A row-strobe fall with the column strobe high latches `addr` as the row. A column-strobe fall with `we_n` low writes `dq_in` to (row, `addr[COL_W-1:0]`). With `we_n` high it loads that cell into `dq_out` one clock later.
- R3: Several column strobes may run inside one row-strobe low period. Read data stays on `dq_out` with `dq_oe` high after the column strobe rises, until the next column fall or until both strobes are high.
- R4: A fall of `we_n` while the column strobe is low in an open row writes `dq_in` into the column latched at the last column fall.
- R5: A row-open cycle that ends without a column fall pulses `refresh_stb` for one clock, with `refresh_row` equal to the latched row address.
- R6: A row-strobe fall with the column strobe low pulses `refresh_stb`, with `refresh_row` equal to the internal counter. The counter then adds one and wraps from 2^ROW_W-1 (2047) to 0.
- R7: The same CBR cycle with `we_n` also low enters test mode. It refreshes from and advances the same counter.
- R8: In test mode a write ignores column bits 1:0 and stores `dq_in` into all four cells sharing the upper column bits.
- R9: In test mode a read returns, per data bit, 1 when the four grouped cells hold the same value and 0 when they differ.
- R10: A single row-only refresh or a single plain CBR refresh (write enable high) leaves test mode.
- R11: In a hidden refresh the column strobe stays low after a read while the row strobe rises and falls again. The read data stays driven, and a CBR refresh from the counter is reported.
- R12: `dq_oe` is 1 only while read data is held and `oe_n` is low. It is 0 throughout row-only and ordinary CBR refresh cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all strobes |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data or test-mode agreement flags |
| dq_oe | output | 1 | Data output drive enable |
| refresh_stb | output | 1 | One-clock pulse per refreshed row |
| refresh_row | output | ROW_W | Row refreshed at the last pulse |

## Verification
Addresses are interleaved so that writes and reads to different rows and columns cannot alias, which shows that the row latch and the column latch are separate. Row-only and CBR refreshes are mixed with accesses: the reported row must switch between the address pins and the counter, and the counter must move only on CBR-type cycles. Test-mode traffic uses one broadcast write, which must read back all-agree, and one later single-cell edit, which must flip exactly one agreement bit. This separates compressed writing from compressed reading, and each exit path is checked by a normal read afterwards. A long run of CBR cycles reaches the counter wrap. Page, read-modify-write, output-enable and hidden-refresh sequences each exercise a different rule for when the data output is held or released.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_ROW_OPEN   = 2'd1,
        ST_CBR_REF    = 2'd2,
        ST_TEST_ENTRY = 2'd3
    } cyc_state_t;
endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall,
    output logic         lead_rise
);
    logic [N-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= lvl_n;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign fall[i] = prev[i] & ~lvl_n[i];
    end

    assign lead_rise = ~prev[0] & lvl_n[0];
endmodule

// File: rtl/refresh_counter.sv
module refresh_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + 1'b1;
    end
endmodule

// File: rtl/cell_array.sv
module cell_array #(
    parameter int MROW_W = 2,
    parameter int COL_W  = 3,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wide,
    input  logic [MROW_W-1:0] row,
    input  logic [COL_W-1:0]  col,
    input  logic [DQ_W-1:0]   wdata,
    output logic [DQ_W-1:0]   rdata,
    output logic [DQ_W-1:0]   ragree
);
    localparam int IDX_W = MROW_W + COL_W;
    localparam int DEPTH = 1 << IDX_W;
    localparam int GRP   = 4;

    logic [DQ_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] idx, grp_base, grp_last;

    assign idx      = {row, col};
    assign grp_base = {row, col[COL_W-1:2], 2'b00};
    assign grp_last = {row, col[COL_W-1:2], 2'b11};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wide) begin
                for (int g = 0; g < GRP; g++)
                    mem[grp_base + IDX_W'(g)] <= wdata;
            end else begin
                mem[idx] <= wdata;
            end
        end
    end

    assign rdata = mem[idx];

    for (genvar b = 0; b < DQ_W; b++) begin : g_bit
        logic [GRP-1:0] v;
        always_comb begin
            for (int g = 0; g < GRP; g++)
                v[g] = mem[grp_base + IDX_W'(g)][b];
        end
        assign ragree[b] = (&v) | ~(|v);
    end

    // R8: a broadcast write leaves the first and last cells of the group equal
    assert_grp_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wide) |=> mem[$past(grp_base)] == mem[$past(grp_last)]);
endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
    import dram_ctl_pkg::*;
#(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 3,
    parameter int MROW_W = 2,
    parameter int DQ_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    input  logic [DQ_W-1:0]  dq_in,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_oe,
    output logic             refresh_stb,
    output logic [ROW_W-1:0] refresh_row
);
    localparam int NSTB = 3;

    cyc_state_t state, state_nx;
    logic [NSTB-1:0] fall;
    logic ras_rise, ras_fall, cas_fall, we_fall;
    logic [ROW_W-1:0] row_q, cnt;
    logic [COL_W-1:0] col_q, mem_col;
    logic col_seen, test_mode, rd_valid;
    logic [DQ_W-1:0] dout_q, rdata, ragree;
    logic cbr_tick, early_wr, late_wr, mem_we;

    strobe_sampler #(.N(NSTB)) u_smp (
        .clk(clk), .rst_n(rst_n), .lvl_n({we_n, cas_n, ras_n}),
        .fall(fall), .lead_rise(ras_rise)
    );
    assign ras_fall = fall[0];
    assign cas_fall = fall[1];
    assign we_fall  = fall[2];

    assign cbr_tick = (state == ST_IDLE) && ras_fall && !cas_n;

    refresh_counter #(.W(ROW_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cbr_tick), .count(cnt)
    );

    assign early_wr = (state == ST_ROW_OPEN) && cas_fall && !we_n;
    assign late_wr  = (state == ST_ROW_OPEN) && we_fall && !cas_n && !cas_fall && col_seen;
    assign mem_we   = early_wr || late_wr;
    assign mem_col  = cas_fall ? addr[COL_W-1:0] : col_q;

    cell_array #(.MROW_W(MROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(mem_we), .wide(test_mode),
        .row(row_q[MROW_W-1:0]), .col(mem_col), .wdata(dq_in),
        .rdata(rdata), .ragree(ragree)
    );

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (cas_n)      state_nx = ST_ROW_OPEN;
                    else if (we_n)  state_nx = ST_CBR_REF;
                    else            state_nx = ST_TEST_ENTRY;
                end
            end
            ST_ROW_OPEN, ST_CBR_REF, ST_TEST_ENTRY: begin
                if (ras_rise) state_nx = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q       <= '0;
            col_q       <= '0;
            col_seen    <= 1'b0;
            test_mode   <= 1'b0;
            rd_valid    <= 1'b0;
            dout_q      <= '0;
            refresh_stb <= 1'b0;
            refresh_row <= '0;
        end else begin
            refresh_stb <= 1'b0;
            if (state == ST_IDLE && ras_fall) begin
                if (cas_n) begin
                    row_q    <= addr;
                    col_seen <= 1'b0;
                end else begin
                    refresh_stb <= 1'b1;
                    refresh_row <= cnt;
                    test_mode   <= !we_n;
                end
            end
            if (state == ST_ROW_OPEN && ras_rise && !col_seen) begin
                refresh_stb <= 1'b1;
                refresh_row <= row_q;
                test_mode   <= 1'b0;
            end
            if (state == ST_ROW_OPEN && cas_fall) begin
                col_q    <= addr[COL_W-1:0];
                col_seen <= 1'b1;
                if (we_n) begin
                    rd_valid <= 1'b1;
                    dout_q   <= test_mode ? ragree : rdata;
                end else begin
                    rd_valid <= 1'b0;
                end
            end
            if (late_wr) rd_valid <= 1'b0;
            if (ras_n && cas_n) rd_valid <= 1'b0;
        end
    end

    assign dq_out = dout_q;
    assign dq_oe  = rd_valid && !oe_n;

    // R12: read data may only start being held inside an open-row access
    assert_drive_in_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> state == ST_ROW_OPEN);

    // R5/R6: every refresh pulse follows a CBR-type entry or a row-open cycle that just closed
    assert_refresh_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb |-> (state == ST_CBR_REF || state == ST_TEST_ENTRY ||
                         (state == ST_IDLE && $past(state) == ST_ROW_OPEN)));

    // R7: the test-entry cycle always leaves test mode active
    assert_test_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TEST_ENTRY |-> test_mode);

    // R10: test mode is left only together with a refresh
    assert_exit_on_refresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> refresh_stb);
endmodule

// File: tb/sim_dram_refresh_ctl.sv
module sim_dram_refresh_ctl;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_WR   = 3'd0;
    localparam logic [2:0] OP_RD   = 3'd1;
    localparam logic [2:0] OP_RONL = 3'd2;
    localparam logic [2:0] OP_CBR  = 3'd3;
    localparam logic [2:0] OP_WCBR = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [10:0] row;
        logic [2:0]  col;
        logic [3:0]  dat;
        logic [10:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{OP_WR,   11'd5,    3'd3, 4'hA, 11'd0},    // R2 write
        '{OP_WR,   11'd2,    3'd6, 4'h5, 11'd0},    // R2 write
        '{OP_RD,   11'd5,    3'd3, 4'h0, 11'hA},    // R2 read back
        '{OP_RD,   11'd2,    3'd6, 4'h0, 11'h5},    // R2 read back
        '{OP_RONL, 11'd1234, 3'd0, 4'h0, 11'd1234}, // R5 row from pins
        '{OP_CBR,  11'd0,    3'd0, 4'h0, 11'd0},    // R1 R6 counter row 0
        '{OP_CBR,  11'd0,    3'd0, 4'h0, 11'd1},    // R6
        '{OP_WCBR, 11'd0,    3'd0, 4'h0, 11'd2},    // R7 enter test mode
        '{OP_WR,   11'd3,    3'd5, 4'h9, 11'd0},    // R8 broadcast write
        '{OP_RD,   11'd3,    3'd4, 4'h0, 11'hF},    // R9 all agree
        '{OP_RONL, 11'd7,    3'd0, 4'h0, 11'd7},    // R10 exit by row-only
        '{OP_RD,   11'd3,    3'd6, 4'h0, 11'h9},    // R8 neighbour got the bit
        '{OP_WR,   11'd3,    3'd7, 4'h1, 11'd0},    // single-cell edit
        '{OP_WCBR, 11'd0,    3'd0, 4'h0, 11'd3},    // R7 re-enter
        '{OP_RD,   11'd3,    3'd5, 4'h0, 11'h7},    // R9 bit3 disagrees
        '{OP_CBR,  11'd0,    3'd0, 4'h0, 11'd4},    // R10 exit by plain CBR
        '{OP_RD,   11'd3,    3'd5, 4'h0, 11'h9}     // R10 normal read again
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dq_out;
    logic dq_oe, refresh_stb;
    logic [10:0] refresh_row;

    int n_chk = 0;
    int n_fail = 0;
    logic [10:0] exp_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_ctl u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe),
        .refresh_stb(refresh_stb), .refresh_row(refresh_row)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_write(input logic [10:0] row, input logic [2:0] col, input logic [3:0] dat);
        ras_n = 1'b0; addr = row; step();
        addr = 11'(col); din = dat; we_n = 1'b0; cas_n = 1'b0; step();
        cas_n = 1'b1; we_n = 1'b1; step();
        ras_n = 1'b1; step(); step();
    endtask

    task automatic do_read(input string req, input logic [10:0] row, input logic [2:0] col,
                           input logic [3:0] exp);
        ras_n = 1'b0; addr = row; step();
        addr = 11'(col); oe_n = 1'b0; cas_n = 1'b0; step();
        check({req, " drive"}, 32'(dq_oe), 32'd1);
        check({req, " data"}, 32'(dq_out), 32'(exp));
        cas_n = 1'b1; step();
        ras_n = 1'b1; step();
        oe_n = 1'b1; step();
    endtask

    task automatic do_ronly(input string req, input logic [10:0] row);
        oe_n = 1'b0; ras_n = 1'b0; addr = row; step();
        ras_n = 1'b1; step();
        check({req, " stb"}, 32'(refresh_stb), 32'd1);
        check({req, " row"}, 32'(refresh_row), 32'(row));
        check("R12 hiz row-only", 32'(dq_oe), 32'd0);
        oe_n = 1'b1; step();
    endtask

    task automatic do_cbr(input string req, input logic wen);
        oe_n = 1'b0; cas_n = 1'b0; we_n = wen; step();
        ras_n = 1'b0; step();
        check({req, " stb"}, 32'(refresh_stb), 32'd1);
        check({req, " row"}, 32'(refresh_row), 32'(exp_cnt));
        check("R12 hiz cbr", 32'(dq_oe), 32'd0);
        exp_cnt = exp_cnt + 11'd1;
        ras_n = 1'b1; we_n = 1'b1; step();
        cas_n = 1'b1; oe_n = 1'b1; step(); step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 dq_oe", 32'(dq_oe), 32'd0);
        check("R1 stb", 32'(refresh_stb), 32'd0);

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].op)
                OP_WR:   do_write(VEC[i].row, VEC[i].col, VEC[i].dat);
                OP_RD:   do_read($sformatf("R2/R8/R9/R10 vec%0d", i), VEC[i].row,
                                 VEC[i].col, VEC[i].exp[3:0]);
                OP_RONL: do_ronly($sformatf("R5/R10 vec%0d", i), VEC[i].row);
                OP_CBR: begin
                    check($sformatf("R6 table vec%0d", i), 32'(exp_cnt), 32'(VEC[i].exp));
                    do_cbr($sformatf("R6 vec%0d", i), 1'b1);
                end
                OP_WCBR: begin
                    check($sformatf("R7 table vec%0d", i), 32'(exp_cnt), 32'(VEC[i].exp));
                    do_cbr($sformatf("R7 vec%0d", i), 1'b0);
                end
                default: ;
            endcase
        end

        // R3: page mode with data held after the column strobe rises
        do_write(11'd6, 3'd0, 4'h3);
        do_write(11'd6, 3'd1, 4'hC);
        ras_n = 1'b0; addr = 11'd6; step();
        addr = 11'd0; oe_n = 1'b0; cas_n = 1'b0; step();
        check("R3 page first", 32'(dq_out), 32'h3);
        cas_n = 1'b1; step();
        check("R3 hold drive", 32'(dq_oe), 32'd1);
        check("R3 hold data", 32'(dq_out), 32'h3);
        addr = 11'd1; cas_n = 1'b0; step();
        check("R3 page second", 32'(dq_out), 32'hC);
        cas_n = 1'b1; step();
        ras_n = 1'b1; step();
        oe_n = 1'b1; step();
        check("R3 release", 32'(dq_oe), 32'd0);

        // R4: read-modify-write
        do_write(11'd6, 3'd2, 4'h7);
        ras_n = 1'b0; addr = 11'd6; step();
        addr = 11'd2; oe_n = 1'b0; cas_n = 1'b0; step();
        check("R4 old data", 32'(dq_out), 32'h7);
        oe_n = 1'b1; din = 4'hE; we_n = 1'b0; step();
        we_n = 1'b1; cas_n = 1'b1; step();
        ras_n = 1'b1; step(); step();
        do_read("R4 new data", 11'd6, 3'd2, 4'hE);

        // R12: output enable gates the drive
        ras_n = 1'b0; addr = 11'd6; step();
        addr = 11'd0; cas_n = 1'b0; step();
        check("R12 oe high", 32'(dq_oe), 32'd0);
        oe_n = 1'b0; step();
        check("R12 oe low", 32'(dq_oe), 32'd1);
        cas_n = 1'b1; step();
        ras_n = 1'b1; step();
        oe_n = 1'b1; step();

        // R11: hidden refresh keeps read data on the bus
        do_write(11'd1, 3'd1, 4'h6);
        ras_n = 1'b0; addr = 11'd1; step();
        addr = 11'd1; oe_n = 1'b0; cas_n = 1'b0; step();
        check("R11 read", 32'(dq_out), 32'h6);
        ras_n = 1'b1; step();
        check("R11 precharge drive", 32'(dq_oe), 32'd1);
        ras_n = 1'b0; step();
        check("R11 stb", 32'(refresh_stb), 32'd1);
        check("R11 row", 32'(refresh_row), 32'(exp_cnt));
        check("R11 still driven", 32'(dq_oe), 32'd1);
        check("R11 data held", 32'(dq_out), 32'h6);
        exp_cnt = exp_cnt + 11'd1;
        ras_n = 1'b1; step();
        cas_n = 1'b1; step();
        oe_n = 1'b1; step();

        // R6: run the counter to its wrap
        while (exp_cnt != 11'd2047) do_cbr("R6 sweep", 1'b1);
        do_cbr("R6 last row", 1'b1);
        check("R6 wrapped", 32'(exp_cnt), 32'd0);
        do_cbr("R6 after wrap", 1'b1);

        finish_run();
    end
endmodule